// File: doc/BRIEF.md
# Line Sensor Readout Timing Sequencer

This block generates the readout timing of a self-scanning photodiode line sensor as digital logic. It runs on an internal clock at twice the pixel clock rate, so every event can land on a half pixel clock. From the pixel clock and the line reset pulse it derives four results. The first is the integration window. The second is a per-channel video-valid window carrying a zero-based channel index. The third is a narrow capture trigger inside each window. The fourth is an end-of-scan pulse after the last channel. The video-valid flag stands in for the analog video output, which is not modelled.

In master mode a scan begins at the first pixel clock falling edge after the line reset falls. In slave mode the scan begins when the external start input rises, and the line reset fall is ignored for this purpose. Driving that input from the preceding sensor's end-of-scan chains several sensors onto one readout line. A build option delays all readout events by 20 pixel clocks, for the extended-start variant. If the line reset rises during a scan, the scan stops and a sticky abort flag is raised.

Time is counted in half pixel clocks, written h. Clock 1 is the starting pixel clock falling edge, at h = 0, and pixel clock k is at h = 2(k-1).

Top module: `line_scan_seq`

## Requirements
- R1: `integ_o` rises at the 8th pixel clock falling edge after `line_rst_i` rises, and falls at the 8th pixel clock falling edge after `line_rst_i` falls. It changes at no other time.
- R2: In master mode (`slave_i` = 0), clock 1 is the first `pclk_i` falling edge after `line_rst_i` falls. Channel 0 video is valid from 18.5 to 20.5 clocks, which is h = 35 to 38 inclusive.
- R3: `trig_o` is high for exactly one half clock in each window, at 19.5 + 4c clocks for channel c. That is h = 37 + 8c. It is never high outside a video window.
- R4: Channel c is valid during h = 35 + 8c to 38 + 8c. `chan_o` equals c and stays constant through that window, and it reads 0 whenever `video_valid_o` is low.
- R5: After the last channel, `eos_o` is high for one pixel clock (two half clocks) starting at h = 35 + 8N. `video_valid_o` stays low from then until the next scan.
- R6: In slave mode, a scan starts at the first `clk_i` edge that samples `ext_start_i` high after it was low. Channel 0 is valid right after that edge, and the same 8-half-clock stride follows. A falling `line_rst_i` does not start a slave scan.
- R7: In master mode `ext_start_i` has no effect on any output.
- R8: With `EXT_START` = 1, every readout event (windows, triggers, end-of-scan) comes 20 clocks (40 half clocks) later than in R2 to R5.
- R9: A `line_rst_i` rise during an active scan ends it at the next edge: video, trigger and end-of-scan go low and `abort_o` rises. `abort_o` stays high until `rst_ni` is asserted. A rise while idle does not set it.
- R10: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock, twice the pixel clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pclk_i | input | 1 | Pixel clock, toggling once per `clk_i` cycle |
| line_rst_i | input | 1 | Line reset pulse; its high time sets the integration period |
| ext_start_i | input | 1 | Scan start in slave mode; held high in master mode |
| slave_i | input | 1 | 1 selects slave mode |
| integ_o | output | 1 | Integration window active |
| video_valid_o | output | 1 | A channel's video is valid |
| chan_o | output | $clog2(N) | Zero-based index of the valid channel |
| trig_o | output | 1 | Capture trigger, one half clock wide |
| eos_o | output | 1 | End of scan |
| abort_o | output | 1 | Sticky: scan aborted by a line reset rise |

## Verification
Each scan result is due a fixed number of `clk_i` edges after the starting edge. The starting edge is two edges after the line reset fall is driven with the pixel clock high. The bench compares video, trigger, channel and end-of-scan against the arithmetic h = 35 + 8c (plus 40 in the extended variant, or measured from the start-edge capture in slave mode) after every edge of the sweep. The integration window is expected to change exactly 16 edges after its `line_rst_i` change is driven. The abort flag is expected one edge after the rise. All outputs are sampled half a `clk_i` period after the edge, once every register on the path has settled.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam int unsigned HALF_LEAD = 35;  // clock 18.5 in half clocks from clock 1
  localparam int unsigned EXT_LEAD  = 40;  // 20 clocks added by extended start
  localparam int unsigned CH_STRIDE = 8;   // 4 clocks per channel
  localparam int unsigned WIN_LEN   = 4;   // 2 clocks of valid video
  localparam int unsigned TRIG_POS  = 2;   // trigger centred in the window
  localparam int unsigned EOS_LEN   = 2;
  localparam int unsigned INT_DLY   = 8;   // pixel clock falls from reset edge to window edge

  function automatic int unsigned lead_of(bit ext);
    return HALF_LEAD + (ext ? EXT_LEAD : 0);
  endfunction
endpackage

// File: rtl/lsq_edge.sv
module lsq_edge #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '0;
    else         q <= sig_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise_o[i] = sig_i[i] & ~q[i];
    assign fall_o[i] = q[i] & ~sig_i[i];
  end
endmodule

// File: rtl/lsq_integ.sv
module lsq_integ #(
  parameter int unsigned DLY = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic d_i,
  output logic integ_o
);
  logic [DLY-1:0] sr;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     sr <= '0;
    else if (fall_i) sr <= {sr[DLY-2:0], d_i};

  assign integ_o = sr[DLY-1];

  assert_integ_on_fall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(integ_o) |-> $past(fall_i));
endmodule

// File: rtl/lsq_scan.sv
module lsq_scan #(
  parameter int unsigned N    = 64,
  parameter int unsigned LEAD = 35,
  parameter int unsigned CW   = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slave_i,
  input  logic          pclk_fall_i,
  input  logic          rst_rise_i,
  input  logic          rst_fall_i,
  input  logic          start_rise_i,
  output logic          video_valid_o,
  output logic [CW-1:0] chan_o,
  output logic          trig_o,
  output logic          eos_o,
  output logic          abort_o
);
  import lsq_pkg::*;

  localparam int unsigned RD_LEN = N * CH_STRIDE;
  localparam int unsigned END_H  = LEAD + RD_LEN + EOS_LEN;
  localparam int unsigned HW     = $clog2(END_H + 1);
  localparam int unsigned SW     = $clog2(CH_STRIDE);

  logic [HW-1:0] h_q, off;
  logic [SW-1:0] slot;
  logic act_q, armed_q, abort_q, in_rd, start_m, start_s;

  assign start_m = !slave_i && armed_q && pclk_fall_i && !act_q;
  assign start_s = slave_i && start_rise_i && !act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0; act_q <= 1'b0; armed_q <= 1'b0; abort_q <= 1'b0;
    end else begin
      if (rst_fall_i)                  armed_q <= 1'b1;
      else if (rst_rise_i || start_m)  armed_q <= 1'b0;

      if (rst_rise_i && act_q) begin
        act_q   <= 1'b0;
        abort_q <= 1'b1;
      end else if (start_m) begin
        act_q <= 1'b1;
        h_q   <= '0;
      end else if (start_s) begin
        act_q <= 1'b1;
        h_q   <= HW'(LEAD);
      end else if (act_q) begin
        if (h_q == HW'(END_H - 1)) act_q <= 1'b0;
        else                       h_q   <= h_q + 1'b1;
      end
    end
  end

  always_comb begin
    off   = h_q - HW'(LEAD);
    slot  = off[SW-1:0];
    in_rd = act_q && (h_q >= HW'(LEAD)) && (off < HW'(RD_LEN));
  end

  assign video_valid_o = in_rd && (slot < SW'(WIN_LEN));
  assign chan_o        = video_valid_o ? off[SW +: CW] : '0;
  assign trig_o        = video_valid_o && (slot == SW'(TRIG_POS));
  assign eos_o         = act_q && (h_q >= HW'(LEAD + RD_LEN));
  assign abort_o       = abort_q;

  assert_trig_in_win_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> video_valid_o);
  assert_trig_narrow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  assert_chan_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (video_valid_o && $past(video_valid_o)) |-> $stable(chan_o));
  assert_eos_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eos_o && video_valid_o));
  assert_abort_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(abort_o) |-> abort_o);
  assert_abort_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> (!video_valid_o && !eos_o && !trig_o));
endmodule

// File: rtl/line_scan_seq.sv
module line_scan_seq #(
  parameter int unsigned N         = 64,
  parameter bit          EXT_START = 1'b0,
  localparam int unsigned CW       = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pclk_i,
  input  logic          line_rst_i,
  input  logic          ext_start_i,
  input  logic          slave_i,
  output logic          integ_o,
  output logic          video_valid_o,
  output logic [CW-1:0] chan_o,
  output logic          trig_o,
  output logic          eos_o,
  output logic          abort_o
);
  import lsq_pkg::*;

  localparam int unsigned LEAD = lead_of(EXT_START);

  logic [2:0] rise, fall;
  logic unused_edges;

  lsq_edge #(.W(3)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({ext_start_i, line_rst_i, pclk_i}),
    .rise_o (rise),
    .fall_o (fall)
  );
  assign unused_edges = ^{rise[0], fall[2]};

  lsq_integ #(.DLY(INT_DLY)) u_integ (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fall_i  (fall[0]),
    .d_i     (line_rst_i),
    .integ_o (integ_o)
  );

  lsq_scan #(.N(N), .LEAD(LEAD), .CW(CW)) u_scan (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .slave_i       (slave_i),
    .pclk_fall_i   (fall[0]),
    .rst_rise_i    (rise[1]),
    .rst_fall_i    (fall[1]),
    .start_rise_i  (rise[2]),
    .video_valid_o (video_valid_o),
    .chan_o        (chan_o),
    .trig_o        (trig_o),
    .eos_o         (eos_o),
    .abort_o       (abort_o)
  );
endmodule

// File: tb/sim_line_scan_seq.sv
module sim_line_scan_seq;
  localparam int N = 64;

  logic clk_i = 1'b0, rst_ni = 1'b0, pclk_i = 1'b0, line_rst_i = 1'b0, xs_b = 1'b1;
  logic       integ0, vv0, tr0, eos0, ab0;
  logic       integ1, vv1, tr1, eos1, ab1;
  logic       integ2, vv2, tr2, eos2, ab2;
  logic [5:0] ch0, ch1, ch2;
  int cyc = 0, n_chk = 0, n_err = 0;

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;
  always @(negedge clk_i) pclk_i <= ~pclk_i;

  line_scan_seq #(.N(N), .EXT_START(1'b0)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pclk_i(pclk_i), .line_rst_i(line_rst_i),
    .ext_start_i(xs_b), .slave_i(1'b0), .integ_o(integ0), .video_valid_o(vv0),
    .chan_o(ch0), .trig_o(tr0), .eos_o(eos0), .abort_o(ab0));
  line_scan_seq #(.N(N), .EXT_START(1'b0)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pclk_i(pclk_i), .line_rst_i(line_rst_i),
    .ext_start_i(eos0), .slave_i(1'b1), .integ_o(integ1), .video_valid_o(vv1),
    .chan_o(ch1), .trig_o(tr1), .eos_o(eos1), .abort_o(ab1));
  line_scan_seq #(.N(N), .EXT_START(1'b1)) u2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pclk_i(pclk_i), .line_rst_i(line_rst_i),
    .ext_start_i(1'b1), .slave_i(1'b0), .integ_o(integ2), .video_valid_o(vv2),
    .chan_o(ch2), .trig_o(tr2), .eos_o(eos2), .abort_o(ab2));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s at cyc %0d: act=%0d exp=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  // off = half clocks since the channel 0 window opens; negative = not started
  task automatic chk_scan(input string who, input int off, input logic v, input logic [5:0] c,
                          input logic t, input logic e);
    bit ev, et, ee;
    int ec;
    ev = (off >= 0) && (off < 8 * N) && (off % 8 < 4);
    ec = ev ? off / 8 : 0;
    et = ev && (off % 8 == 2);
    ee = (off >= 8 * N) && (off < 8 * N + 2);
    chk({who, " video R2 R4"}, int'(v), int'(ev));
    chk({who, " chan R4"}, int'(c), ec);
    chk({who, " trig R3"}, int'(t), int'(et));
    chk({who, " eos R5"}, int'(e), int'(ee));
  endtask

  task automatic wait_pclk_high();
    step();
    while (pclk_i != 1'b1) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R10: act=running exp=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int c, k0;
    repeat (3) step();
    // R10: reset state
    chk("reset integ R10", int'(integ0 | integ1 | integ2), 0);
    chk("reset video R10", int'(vv0 | vv1 | vv2), 0);
    chk("reset trig/eos R10", int'(tr0 | tr1 | tr2 | eos0 | eos1 | eos2), 0);
    chk("reset abort R10", int'(ab0 | ab1 | ab2), 0);
    chk("reset chan R10", int'(ch0 | ch1 | ch2), 0);
    rst_ni = 1'b1;
    repeat (4) step();

    // R1: integration opens 8 pclk falls (16 edges) after reset rise
    wait_pclk_high();
    line_rst_i = 1'b1;
    c = cyc;
    for (int i = 0; i < 40; i++) begin
      step();
      chk("integ rise R1", int'(integ0), int'(cyc >= c + 16));
      chk("integ rise R1 slave", int'(integ1), int'(cyc >= c + 16));
      chk("idle rise no abort R9", int'(ab0), 0);
    end

    // R2..R8: one frame, master + chained slave + extended variant
    wait_pclk_high();
    line_rst_i = 1'b0;
    k0 = cyc + 2;
    while (cyc < k0) step();
    for (int h = 0; h <= 1100; h++) begin
      xs_b = ((h / 3) % 2) == 1;  // R7: toggling ignored by master
      chk("integ fall R1", int'(integ0), int'(h < 14));
      chk_scan("u0 master R7", h - 35, vv0, ch0, tr0, eos0);
      chk_scan("u1 slave R6", h - 548, vv1, ch1, tr1, eos1);
      chk_scan("u2 ext R8", h - 75, vv2, ch2, tr2, eos2);
      chk("no abort R9", int'(ab0 | ab1 | ab2), 0);
      step();
    end
    xs_b = 1'b1;

    // R9: reset rise mid-scan aborts masters; idle slave unaffected
    wait_pclk_high();
    line_rst_i = 1'b1;
    repeat (40) step();
    wait_pclk_high();
    line_rst_i = 1'b0;
    k0 = cyc + 2;
    while (cyc < k0 + 100) step();
    chk("mid scan video R2", int'(vv0), int'(((100 - 35) % 8) < 4));
    chk("pre abort R9", int'(ab0), 0);
    line_rst_i = 1'b1;
    for (int i = 0; i < 30; i++) begin
      step();
      chk("abort u0 R9", int'(ab0), 1);
      chk("abort u2 R9", int'(ab2), 1);
      chk("abort idle slave R9", int'(ab1), 0);
      chk("abort quiet R9", int'(vv0 | tr0 | eos0 | vv2 | tr2 | eos2), 0);
    end
    line_rst_i = 1'b0;
    repeat (10) step();
    chk("abort sticky R9", int'(ab0), 1);

    rst_ni = 1'b0;
    step();
    chk("abort cleared R10", int'(ab0 | ab2), 0);
    chk("reset outputs R10", int'(integ0 | vv0 | tr0 | eos0 | (|ch0)), 0);
    rst_ni = 1'b1;
    step();

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule